// File: doc/BRIEF.md
# SPI Configuration Loader for a Target FPGA

This block loads a configuration image into a target FPGA through the target's SPI configuration port. On a start pulse it drives the target's active-low reset low. It asserts chip select at the same moment, so the target comes out of reset in SPI-slave configuration mode. After releasing reset it confirms that the target's done line is low. It then keeps chip select low for a housekeeping wait and releases it. After that it streams the image, which arrives as bytes on a valid/ready stream with a last flag.

When the image has been sent, the loader waits for the done line to go high. It then clocks out a run of zero bytes that starts the loaded design and reports success. If the done line reads high right after reset, the run ends with a reset error. If it reads low after the image, the run ends with an image error. Every delay is a parameter counted in system clock cycles. The SPI clock rate and the reset width are checked against the target's limits when the design is elaborated.

Top module: `fpga_cfg_loader`

## Requirements
- R1: A start pulse in the idle state drives `cfg_rst_n` low and `spi_cs_n` low in the same cycle, and `spi_cs_n` stays low for as long as `cfg_rst_n` is low.
- R2: `cfg_rst_n` stays low for at least `RESET_CYC` clock cycles. Elaboration fails if `RESET_CYC` is shorter than 200 ns of the system clock.
- R3: If the synchronized done input is high after reset release and a settle wait, `err_reset` is set, `spi_cs_n` goes high, the loader returns to idle and it accepts no image byte.
- R4: After reset release, `spi_cs_n` stays low for at least `HOUSEKEEP_CYC` cycles and then goes high before any image byte is accepted.
- R5: The SPI clock idles low and each high phase lasts exactly `SCK_HALF` cycles. `spi_mosi` changes only while `spi_sck` is low, so the target samples on the rising edge. Elaboration fails if the resulting clock is outside 1 MHz to 25 MHz.
- R6: Each byte is sent most significant bit first. A byte is taken only in a cycle where both `s_valid` and `s_ready` are high. `spi_sck` stays low while no byte is being shifted.
- R7: `spi_cs_n` is low while image bytes and activation bytes are shifted, and it goes high once the final activation byte is done.
- R8: If done reads high after the last image byte, `ACT_BYTES` (default 7, at least 49 bits) bytes of value 0x00 are sent, after which `ok` is set.
- R9: If done reads low after the last image byte, `err_image` is set, `spi_cs_n` goes high and no activation byte is sent.
- R10: A start pulse while `busy` is high has no effect: reset is not asserted again and the stream carries on.
- R11: `ok`, `err_reset` and `err_image` hold their value while the loader is idle, and an accepted start clears all three.
- R12: During and after synchronous reset, `cfg_rst_n`=1, `spi_cs_n`=1, `spi_sck`=0, `spi_mosi`=0, and `busy`, `ok`, `err_reset`, `err_image` and `s_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a load |
| s_data | input | 8 | Image byte |
| s_valid | input | 1 | Image byte present |
| s_last | input | 1 | Marks the final image byte |
| s_ready | output | 1 | Loader takes the byte this cycle |
| done_in | input | 1 | Target's done line (asynchronous) |
| cfg_rst_n | output | 1 | Target reset, active low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sck | output | 1 | SPI clock (mode 0) |
| spi_mosi | output | 1 | SPI data to target |
| busy | output | 1 | A load is in progress |
| ok | output | 1 | Last load finished and was activated |
| err_reset | output | 1 | Done was high after reset release |
| err_image | output | 1 | Done stayed low after the image |

## Verification
A new start pulse can land in the same cycle in which the loader accepts the final image byte. In that cycle the loader is busy, and it also marks the end of the stream. The bench raises `start` exactly when it presents the `s_last` byte with `s_ready` high. It then checks that `cfg_rst_n` never goes low again. A scoreboard compares every byte seen on the SPI lines with the image and the zero bytes expected after it, so the run must still end with `ok` set.

// File: rtl/fpga_cfg_pkg.sv
package fpga_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_HOLD,
        ST_SETTLE_RST,
        ST_HOUSEKEEP,
        ST_CS_GAP,
        ST_XFER,
        ST_SETTLE_IMG,
        ST_ACTIVATE
    } load_state_e;

    // cycles waited before the synchronized done line is trusted
    localparam int SYNC_SETTLE = 3;

    localparam longint SCK_MIN_HZ = 64'd1_000_000;
    localparam longint SCK_MAX_HZ = 64'd25_000_000;

    function automatic bit sck_rate_ok(longint clk_hz, longint half_cyc);
        longint f;
        f = clk_hz / (2 * half_cyc);
        return (f >= SCK_MIN_HZ) && (f <= SCK_MAX_HZ);
    endfunction

    // 200 ns minimum: cycles * 5e6 >= clk_hz
    function automatic bit reset_width_ok(longint clk_hz, longint cyc);
        return (cyc * 64'd5_000_000) >= clk_hz;
    endfunction

endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cfg_cycle_timer.sv
module cfg_cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)           cnt <= '0;
        else if (load)     cnt <= val;
        else if (cnt != 0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/cfg_spi_shifter.sv
module cfg_spi_shifter #(
    parameter int SCK_HALF = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] din,
    output logic       active,
    output logic       sck,
    output logic       mosi
);
    localparam int HW = $clog2(SCK_HALF + 1);

    logic [7:0]    sh;
    logic [2:0]    bit_idx;
    logic [HW-1:0] hcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            bit_idx <= '0;
            hcnt    <= '0;
            sck     <= 1'b0;
            active  <= 1'b0;
        end else if (load && !active) begin
            sh      <= din;
            bit_idx <= '0;
            hcnt    <= '0;
            sck     <= 1'b0;
            active  <= 1'b1;
        end else if (active) begin
            if (hcnt == HW'(SCK_HALF - 1)) begin
                hcnt <= '0;
                if (!sck) begin
                    sck <= 1'b1;
                end else begin
                    sck <= 1'b0;
                    if (bit_idx == 3'd7) begin
                        active <= 1'b0;
                    end else begin
                        sh      <= {sh[6:0], 1'b0};
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    assign mosi = active & sh[7];
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
    import fpga_cfg_pkg::*;
#(
    parameter int CLK_HZ        = 125_000_000,
    parameter int SCK_HALF      = 4,
    parameter int RESET_CYC     = 125,
    parameter int HOUSEKEEP_CYC = 150_000,
    parameter int ACT_BYTES     = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] s_data,
    input  logic       s_valid,
    input  logic       s_last,
    output logic       s_ready,
    input  logic       done_in,
    output logic       cfg_rst_n,
    output logic       spi_cs_n,
    output logic       spi_sck,
    output logic       spi_mosi,
    output logic       busy,
    output logic       ok,
    output logic       err_reset,
    output logic       err_image
);
    localparam int T_MAX1 = (RESET_CYC > HOUSEKEEP_CYC) ? RESET_CYC : HOUSEKEEP_CYC;
    localparam int T_MAX2 = (T_MAX1 > SCK_HALF) ? T_MAX1 : SCK_HALF;
    localparam int T_MAX  = (T_MAX2 > SYNC_SETTLE) ? T_MAX2 : SYNC_SETTLE;
    localparam int TW     = $clog2(T_MAX + 1);
    localparam int AW     = $clog2(ACT_BYTES + 1);

    if (!sck_rate_ok(CLK_HZ, SCK_HALF)) begin : g_bad_sck
        $error("SPI clock outside 1..25 MHz for given CLK_HZ and SCK_HALF");
    end
    if (!reset_width_ok(CLK_HZ, RESET_CYC)) begin : g_bad_rst
        $error("RESET_CYC shorter than 200 ns");
    end

    load_state_e   state, state_nx;
    logic          done_s;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          sh_load, sh_active;
    logic [7:0]    sh_din;
    logic          last_seen;
    logic [AW-1:0] act_cnt;

    cfg_sync2 i_done_sync (.clk(clk), .rst(rst), .d(done_in), .q(done_s));

    cfg_cycle_timer #(.W(TW)) i_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
    );

    cfg_spi_shifter #(.SCK_HALF(SCK_HALF)) i_shifter (
        .clk(clk), .rst(rst), .load(sh_load), .din(sh_din),
        .active(sh_active), .sck(spi_sck), .mosi(spi_mosi)
    );

    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_din   = '0;
        s_ready  = 1'b0;
        unique case (state)
            ST_IDLE: if (start) begin
                state_nx = ST_RST_HOLD;
                tmr_load = 1'b1;
                tmr_val  = TW'(RESET_CYC - 1);
            end
            ST_RST_HOLD: if (tmr_zero) begin
                state_nx = ST_SETTLE_RST;
                tmr_load = 1'b1;
                tmr_val  = TW'(SYNC_SETTLE - 1);
            end
            ST_SETTLE_RST: if (tmr_zero) begin
                if (done_s) begin
                    state_nx = ST_IDLE;
                end else begin
                    state_nx = ST_HOUSEKEEP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HOUSEKEEP_CYC - 1);
                end
            end
            ST_HOUSEKEEP: if (tmr_zero) begin
                state_nx = ST_CS_GAP;
                tmr_load = 1'b1;
                tmr_val  = TW'(SCK_HALF - 1);
            end
            ST_CS_GAP: if (tmr_zero) state_nx = ST_XFER;
            ST_XFER: begin
                s_ready = !sh_active && !last_seen;
                if (s_valid && s_ready) begin
                    sh_load = 1'b1;
                    sh_din  = s_data;
                end
                if (last_seen && !sh_active) begin
                    state_nx = ST_SETTLE_IMG;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SYNC_SETTLE - 1);
                end
            end
            ST_SETTLE_IMG: if (tmr_zero) state_nx = done_s ? ST_ACTIVATE : ST_IDLE;
            ST_ACTIVATE: if (!sh_active) begin
                if (act_cnt == AW'(ACT_BYTES)) state_nx = ST_IDLE;
                else                           sh_load  = 1'b1;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            last_seen <= 1'b0;
            act_cnt   <= '0;
            ok        <= 1'b0;
            err_reset <= 1'b0;
            err_image <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                last_seen <= 1'b0;
                act_cnt   <= '0;
                ok        <= 1'b0;
                err_reset <= 1'b0;
                err_image <= 1'b0;
            end
            if (state == ST_SETTLE_RST && tmr_zero && done_s) err_reset <= 1'b1;
            if (state == ST_XFER && s_valid && s_ready && s_last) last_seen <= 1'b1;
            if (state == ST_SETTLE_IMG && tmr_zero && !done_s) err_image <= 1'b1;
            if (state == ST_ACTIVATE && sh_load) act_cnt <= act_cnt + 1'b1;
            if (state == ST_ACTIVATE && state_nx == ST_IDLE) ok <= 1'b1;
        end
    end

    assign busy      = (state != ST_IDLE);
    assign cfg_rst_n = (state != ST_RST_HOLD);
    assign spi_cs_n  = (state == ST_IDLE) || (state == ST_CS_GAP);
endmodule

// File: rtl/fpga_cfg_loader_chk.sv
module fpga_cfg_loader_chk #(
    parameter int RESET_CYC = 125
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic s_ready,
    input logic cfg_rst_n,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic spi_mosi,
    input logic busy,
    input logic ok,
    input logic err_reset,
    input logic err_image
);
    int unsigned low_cnt;

    always_ff @(posedge clk) begin
        if (rst || cfg_rst_n) low_cnt <= 0;
        else                  low_cnt <= low_cnt + 1;
    end

    assert_cs_with_reset_R1: assert property (@(posedge clk) disable iff (rst)
        !cfg_rst_n |-> !spi_cs_n);

    assert_reset_width_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_rst_n) |-> (low_cnt >= RESET_CYC));

    assert_reset_fail_release_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(err_reset) |-> (spi_cs_n && !busy));

    assert_mosi_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    assert_sck_inside_cs_R7: assert property (@(posedge clk) disable iff (rst)
        spi_sck |-> !spi_cs_n);

    assert_ready_gated_R6: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (busy && !spi_cs_n && !spi_sck));

    assert_image_fail_release_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_image) |-> spi_cs_n);

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start && cfg_rst_n) |=> cfg_rst_n);

    assert_status_held_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable({ok, err_reset, err_image}));

    assert_status_single_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ok, err_reset, err_image}));
endmodule

bind fpga_cfg_loader fpga_cfg_loader_chk #(.RESET_CYC(RESET_CYC)) i_chk (
    .clk(clk), .rst(rst), .start(start), .s_ready(s_ready),
    .cfg_rst_n(cfg_rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .busy(busy), .ok(ok),
    .err_reset(err_reset), .err_image(err_image)
);

// File: tb/test_fpga_cfg_loader.sv
module test_fpga_cfg_loader;
    localparam int CLK_HZ        = 125_000_000;
    localparam int SCK_HALF      = 3;
    localparam int RESET_CYC     = 25;
    localparam int HOUSEKEEP_CYC = 60;
    localparam int ACT_BYTES     = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] s_data = '0;
    logic       s_valid = 1'b0;
    logic       s_last = 1'b0;
    logic       s_ready;
    logic       done_in = 1'b0;
    logic       cfg_rst_n, spi_cs_n, spi_sck, spi_mosi;
    logic       busy, ok, err_reset, err_image;

    always #4 clk = ~clk;

    fpga_cfg_loader #(
        .CLK_HZ(CLK_HZ), .SCK_HALF(SCK_HALF), .RESET_CYC(RESET_CYC),
        .HOUSEKEEP_CYC(HOUSEKEEP_CYC), .ACT_BYTES(ACT_BYTES)
    ) i_fpga_cfg_loader (
        .clk(clk), .rst(rst), .start(start), .s_data(s_data),
        .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .done_in(done_in), .cfg_rst_n(cfg_rst_n), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .busy(busy), .ok(ok),
        .err_reset(err_reset), .err_image(err_image)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];

    task automatic chk(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: rebuild bytes from rising SPI clock edges, MSB first (R6)
    logic [7:0] mon_sh = '0;
    int         mon_n = 0;
    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            mon_sh = {mon_sh[6:0], spi_mosi};
            mon_n++;
            if (mon_n == 8) begin
                mon_n = 0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected byte on SPI", mon_sh, -1);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(mon_sh == e, "R6", "SPI byte", mon_sh, e);
                end
            end
        end
    end

    // high phase width of the SPI clock (R5)
    int hi_cnt = 0;
    always @(negedge clk) begin
        if (!rst && spi_sck) begin
            hi_cnt++;
        end else if (hi_cnt != 0) begin
            chk(hi_cnt == SCK_HALF, "R5", "sck high cycles", hi_cnt, SCK_HALF);
            hi_cnt = 0;
        end
    end

    task automatic wait_idle(output int rst_lows);
        rst_lows = 0;
        while (busy) begin
            @(negedge clk);
            if (!cfg_rst_n) rst_lows++;
        end
    endtask

    task automatic run_load(input int nbytes, input bit done_rst, input bit done_img,
                            input bit poke, input int gap, input int seed);
        int lowc, hkc, cs_bad, relows;
        done_in = done_rst;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R1", "busy after start", busy, 1);
        chk(!cfg_rst_n && !spi_cs_n, "R1", "reset and cs low together",
            {cfg_rst_n, spi_cs_n}, 0);
        chk({ok, err_reset, err_image} == 3'b000, "R11", "status cleared by start",
            {ok, err_reset, err_image}, 0);
        lowc = 0; cs_bad = 0;
        while (!cfg_rst_n) begin
            lowc++;
            if (spi_cs_n) cs_bad++;
            @(negedge clk);
        end
        chk(cs_bad == 0, "R1", "cs high while reset low", cs_bad, 0);
        chk(lowc >= RESET_CYC, "R2", "reset low cycles", lowc, RESET_CYC);
        if (done_rst) begin
            wait_idle(relows);
            chk(err_reset == 1'b1, "R3", "err_reset", err_reset, 1);
            chk(ok == 1'b0 && err_image == 1'b0, "R3", "other status", {ok, err_image}, 0);
            chk(spi_cs_n == 1'b1 && s_ready == 1'b0, "R3", "cs released, no ready",
                {spi_cs_n, s_ready}, 2);
            return;
        end
        hkc = 0;
        while (!spi_cs_n) begin
            hkc++;
            chk(s_ready == 1'b0, "R4", "ready during housekeeping", s_ready, 0);
            @(negedge clk);
        end
        chk(hkc >= HOUSEKEEP_CYC, "R4", "housekeeping cs low cycles", hkc, HOUSEKEEP_CYC);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R4", "cs high before image", spi_cs_n, 1);
        for (int i = 0; i < nbytes; i++) begin
            s_valid = 1'b1;
            s_data  = 8'(seed + i * 8'h4B) ^ 8'h96;
            s_last  = (i == nbytes - 1);
            while (!s_ready) @(negedge clk);
            exp_q.push_back(s_data);
            if (s_last) begin
                done_in = done_img;
                if (poke) start = 1'b1;
                if (done_img)
                    for (int k = 0; k < ACT_BYTES; k++) exp_q.push_back(8'h00);
            end
            @(negedge clk);
            start   = 1'b0;
            s_valid = 1'b0;
            s_last  = 1'b0;
            if (i != nbytes - 1) begin
                chk(spi_cs_n == 1'b0, "R7", "cs low during image", spi_cs_n, 0);
                repeat (gap) @(negedge clk);
            end
        end
        wait_idle(relows);
        chk(relows == 0, "R10", "reset reasserted by start while busy", relows, 0);
        chk(ok == done_img, "R8", "ok", ok, done_img);
        chk(err_image == !done_img, "R9", "err_image", err_image, !done_img);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R7", "cs released at end",
            {spi_cs_n, spi_sck}, 2);
        chk(exp_q.size() == 0, "R8", "bytes still expected", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({cfg_rst_n, spi_cs_n, spi_sck, spi_mosi} == 4'b1100, "R12",
            "pins in reset", {cfg_rst_n, spi_cs_n, spi_sck, spi_mosi}, 12);
        chk({busy, ok, err_reset, err_image, s_ready} == 5'b0, "R12",
            "status in reset", {busy, ok, err_reset, err_image, s_ready}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({cfg_rst_n, spi_cs_n, busy} == 3'b110, "R12", "idle after reset",
            {cfg_rst_n, spi_cs_n, busy}, 6);

        run_load(3, 1'b1, 1'b0, 1'b0, 0, 0);        // done stuck high
        run_load(4, 1'b0, 1'b1, 1'b1, 0, 8'h11);    // good, start poked at last byte
        repeat (40) @(negedge clk);
        chk(ok == 1'b1 && !busy, "R11", "ok held while idle", ok, 1);
        run_load(3, 1'b0, 1'b0, 1'b0, 5, 8'h3C);    // image rejected
        repeat (20) @(negedge clk);
        chk(err_image == 1'b1, "R11", "err_image held while idle", err_image, 1);
        run_load(6, 1'b0, 1'b1, 1'b0, 2, 8'hE7);    // good, gaps in stream

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule